// File: doc/BRIEF.md
# Staged Rotate With Exchange Unit

This block computes a 32-bit rotate in which each bit position can take its own shift amount. It takes a source word, a primary 5-bit amount, an alternate 5-bit amount and a stripe flag. The source is first copied into both halves of a 64-bit working value. That value then passes through five conditional-move stages, with move distances of 16, 8, 4, 2 and 1. In each stage a bit takes the value of the bit one distance above it, or keeps its own value. A bit of the selected amount decides which. The bit's own index decides whether the primary or the alternate amount is selected. The low 32 bits of the last stage form the result, sign-extended to 64 bits.

When both amounts are equal and stripe is clear, the unit behaves as a plain rotate right. Giving the two amounts different values makes groups of bit positions move by different distances. Setting stripe inverts the selected amount in the first stage, for indexes whose bit 2 is clear. A parameter adds an output register with a valid flag that is one cycle late.

Top module: `rotx_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, the output register is cleared: out_valid is 0 and result is 0 at the next sample.
- R2: With the output register enabled (OUT_REG=1, default), out_valid equals in_valid of the previous cycle. Every accepted input gives exactly one result, in order.
- R3: result loads only in a cycle where in_valid is 1. Otherwise it keeps its previous value, whatever the data inputs do.
- R4: When shamt equals shamt_alt and stripe is 0, result[31:0] is src rotated right by shamt. This holds for all 32 amounts.
- R5: The working value is {src, src}. Stage k (k = 0..4) has distance d = 16>>k and updates positions 0 to 30+d. Higher positions pass through unchanged. Position i takes bit i+d of the previous stage's output when bit 4-k of its selected amount is 1, and otherwise keeps its value. In stages 0..3, index bit 3-k picks the amount: 1 selects shamt, 0 selects shamt_alt. Stage 4 always uses shamt.
- R6: In stage 0 only, when stripe is 1 and index bit 2 is 0, the selected amount is inverted before its bit 4 is tested. Example: src=0x0000FFFF with both amounts 0 and stripe 1 gives 0x000000000F0FF0F0.
- R7: result[63:32] always equals 32 copies of result[31].
- R8: With both amounts 0 and stripe 0, result is src sign-extended. Example: src=0x80000001 gives 0xFFFFFFFF80000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src | input | 32 | Source word |
| shamt | input | 5 | Primary shift amount |
| shamt_alt | input | 5 | Alternate shift amount |
| stripe | input | 1 | Invert the first-stage amount for positions whose index bit 2 is clear |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Sign-extended 32-bit result |

## Verification
The assertions assume that in_valid and the operand inputs are known (not X) at every rising edge after reset. They also assume that operands matter only in cycles where in_valid is 1. The bench drives every input on the falling edge, so the values are settled before each rising edge. While in_valid is low it changes the data inputs on purpose, to show that they are ignored. The rotate-equivalence property applies only to inputs with equal amounts and stripe clear. The bench sweeps all 32 such amounts and also drives independent random amounts with stripe set and cleared.

// File: rtl/rotx_pkg.sv
// Package: shared widths, control bundle and stage geometry for the
// rotate-with-exchange datapath. Stage geometry is computed, not tabulated.
package rotx_pkg;
    localparam int SRC_W  = 32;
    localparam int WORK_W = 2 * SRC_W;
    localparam int RES_W  = 64;
    localparam int AMT_W  = 5;
    localparam int NSTAGE = AMT_W;

    // Operand control fields travelling with the source word.
    typedef struct packed {
        logic [AMT_W-1:0] pri;
        logic [AMT_W-1:0] alt;
        logic             stripe;
    } rotx_ctl_t;

    // Move distance of stage k: halves from stage to stage.
    function automatic int stage_dist(input int k);
        return 1 << (AMT_W - 1 - k);
    endfunction

    // Highest bit position updated by stage k.
    function automatic int stage_last(input int k);
        return SRC_W - 2 + stage_dist(k);
    endfunction

    // Index bit that selects the amount in stage k; -1 means primary only.
    function automatic int stage_sel_bit(input int k);
        return AMT_W - 2 - k;
    endfunction

    // Amount bit tested by stage k.
    function automatic int stage_amt_bit(input int k);
        return AMT_W - 1 - k;
    endfunction
endpackage

// File: rtl/rotx_stage.sv
// Module: one conditional-move stage. Each position up to LAST selects the
// primary or alternate amount from its own index. With STRIPE_EN it may
// invert that amount, and then it takes din[i+DIST] when bit AMT_BIT is set.
// Assumes LAST + DIST < W. Positions above LAST pass through unchanged.
// Purely combinational; reads only din, never its own output.
module rotx_stage
    import rotx_pkg::*;
#(
    parameter int W         = WORK_W,
    parameter int DIST      = 16,
    parameter int LAST      = 46,
    parameter int SEL_BIT   = 3,
    parameter int AMT_BIT   = 4,
    parameter bit STRIPE_EN = 1'b0
) (
    input  logic [W-1:0] din,
    input  rotx_ctl_t    ctl,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i <= LAST) begin : g_move
            logic [AMT_W-1:0] pick;
            logic [AMT_W-1:0] eff;
            // Amount chosen by the position's index.
            if (SEL_BIT < 0) begin : g_pri_only
                assign pick = ctl.pri;
            end else if (((i >> SEL_BIT) & 1) == 1) begin : g_pri
                assign pick = ctl.pri;
            end else begin : g_alt
                assign pick = ctl.alt;
            end
            // Optional stripe inversion for positions with index bit 2 clear.
            if (STRIPE_EN && (((i >> 2) & 1) == 0)) begin : g_stripe
                assign eff = ctl.stripe ? ~pick : pick;
            end else begin : g_plain
                assign eff = pick;
            end
            // Conditional move from the position DIST above.
            assign dout[i] = eff[AMT_BIT] ? din[i+DIST] : din[i];
        end else begin : g_pass
            assign dout[i] = din[i];
        end
    end
endmodule

// File: rtl/rotx_core.sv
// Module: combinational rotate-with-exchange core. Doubles the source word,
// chains NSTAGE stages of decreasing distance, and sign-extends the low half
// of the last stage. Assumes the package geometry (distances 16..1).
module rotx_core
    import rotx_pkg::*;
(
    input  logic [SRC_W-1:0] src,
    input  rotx_ctl_t        ctl,
    output logic [RES_W-1:0] res
);
    logic [WORK_W-1:0] work [NSTAGE+1];

    // Working value: the source word in both halves.
    assign work[0] = {src, src};

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        rotx_stage #(
            .W         (WORK_W),
            .DIST      (stage_dist(k)),
            .LAST      (stage_last(k)),
            .SEL_BIT   (stage_sel_bit(k)),
            .AMT_BIT   (stage_amt_bit(k)),
            .STRIPE_EN (k == 0)
        ) u_stage (
            .din  (work[k]),
            .ctl  (ctl),
            .dout (work[k+1])
        );
    end

    // Sign-extend the low SRC_W bits of the final stage.
    assign res = {{(RES_W-SRC_W){work[NSTAGE][SRC_W-1]}}, work[NSTAGE][SRC_W-1:0]};
endmodule

// File: rtl/rotx_outreg.sv
// Module: optional output register. With REG=1 the data loads only on vin,
// and vout is vin delayed by one cycle. Both clear on a synchronous
// active-low reset. With REG=0 it is a pass-through.
module rotx_outreg #(
    parameter bit REG = 1'b1,
    parameter int W   = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vin,
    input  logic [W-1:0] din,
    output logic         vout,
    output logic [W-1:0] dout
);
    if (REG) begin : g_reg
        // Valid pipeline flag.
        always_ff @(posedge clk) begin
            if (!rst_n) vout <= 1'b0;
            else        vout <= vin;
        end
        // Data register, loaded on valid only.
        always_ff @(posedge clk) begin
            if (!rst_n)   dout <= '0;
            else if (vin) dout <= din;
        end
    end else begin : g_comb
        assign vout = vin;
        assign dout = din;
    end
endmodule

// File: rtl/rotx_unit.sv
// Module: top of the rotate-with-exchange unit. It bundles the controls,
// runs the combinational core and optionally registers the result
// (OUT_REG). Assumes inputs are stable around the rising edge.
module rotx_unit
    import rotx_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      src,
    input  logic [4:0]       shamt,
    input  logic [4:0]       shamt_alt,
    input  logic             stripe,
    output logic             out_valid,
    output logic [63:0]      result
);
    rotx_ctl_t        ctl;
    logic [RES_W-1:0] core_res;

    // Gather the control fields.
    assign ctl = '{pri: shamt, alt: shamt_alt, stripe: stripe};

    rotx_core u_core (
        .src (src),
        .ctl (ctl),
        .res (core_res)
    );

    rotx_outreg #(.REG(OUT_REG), .W(RES_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .din   (core_res),
        .vout  (out_valid),
        .dout  (result)
    );
endmodule

// File: rtl/rotx_unit_chk.sv
// Module: assertion checker for rotx_unit, attached by bind. It checks
// reset, latency, hold, rotate equivalence and sign extension at the ports.
module rotx_unit_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] src,
    input logic [4:0]  shamt,
    input logic [4:0]  shamt_alt,
    input logic        stripe,
    input logic        out_valid,
    input logic [63:0] result
);
    // Plain rotate right used as an independent reference.
    function automatic logic [31:0] ror32(input logic [31:0] v, input logic [4:0] s);
        logic [63:0] dbl;
        dbl = {v, v} >> s;
        return dbl[31:0];
    endfunction

    p_sign_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result[63:32] == {32{result[31]}});

    if (OUT_REG) begin : g_reg
        p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (!out_valid && result == 64'd0));
        p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid)));
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !in_valid) |=> $stable(result));
        p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && shamt == shamt_alt && !stripe)
            |=> result[31:0] == ror32($past(src), $past(shamt)));
    end else begin : g_comb
        p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
        p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (shamt == shamt_alt && !stripe) |-> result[31:0] == ror32(src, shamt));
    end
endmodule

bind rotx_unit rotx_unit_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src       (src),
    .shamt     (shamt),
    .shamt_alt (shamt_alt),
    .stripe    (stripe),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/rotx_unit_bench.sv
// Scoreboard bench: a driver task queues expected results; a monitor pops
// and compares them on the falling edge when out_valid is seen.
module rotx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src = '0;
    logic [4:0]  shamt = '0;
    logic [4:0]  shamt_alt = '0;
    logic        stripe = 1'b0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    rotx_unit #(.OUT_REG(1'b1)) u_rotx_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .shamt(shamt), .shamt_alt(shamt_alt), .stripe(stripe),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference built from the staged description (R5, R6, R7).
    function automatic logic [63:0] model(input logic [31:0] s, input logic [4:0] p,
                                          input logic [4:0] a, input logic st);
        logic [63:0] cur;
        logic [63:0] nxt;
        logic [4:0]  amt;
        cur = {s, s};
        for (int k = 0; k < 5; k++) begin
            nxt = cur;
            for (int i = 0; i <= 30 + (16 >> k); i++) begin
                if (k == 4) amt = p;
                else amt = (((i >> (3 - k)) & 1) == 1) ? p : a;
                if (k == 0 && st && (((i >> 2) & 1) == 0)) amt = ~amt;
                if (amt[4-k]) nxt[i] = cur[i + (16 >> k)];
            end
            cur = nxt;
        end
        return {{32{cur[31]}}, cur[31:0]};
    endfunction

    // Driver: present one valid operand set and queue its expected result.
    task automatic send(input logic [31:0] s, input logic [4:0] p, input logic [4:0] a,
                        input logic st, input logic [63:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; src = s; shamt = p; shamt_alt = a; stripe = st;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Driver: an idle cycle with scrambled, ignored data.
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; src = $urandom; shamt = 5'($urandom);
        shamt_alt = 5'($urandom); stripe = 1'($urandom);
    endtask

    // Monitor: compare each produced result with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", result, 64'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(result === it.exp, it.tag, result, it.exp);
                check(result[63:32] === {32{result[31]}}, "R7 sign extension",
                      result, {{32{result[31]}}, result[31:0]});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        logic [63:0] held;
        // R1: reset wins over a valid input.
        in_valid = 1'b1; src = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check(result === 64'd0, "R1 result in reset", result, 64'd0);
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R8: identity with zero amounts.
        send(32'h80000001, 5'd0, 5'd0, 1'b0, 64'hFFFFFFFF80000001, "R8 identity");
        // R6: stripe with zero amounts.
        send(32'h0000FFFF, 5'd0, 5'd0, 1'b1, 64'h000000000F0FF0F0, "R6 stripe");

        // R4: rotate sweep over all amounts.
        for (int s = 0; s < 32; s++) begin
            logic [63:0] d;
            d = {32'h9E3779B9, 32'h9E3779B9} >> s;
            send(32'h9E3779B9, 5'(s), 5'(s), 1'b0, {{32{d[31]}}, d[31:0]}, "R4 rotate");
        end

        // R5/R6: independent amounts, stripe both ways.
        for (int n = 0; n < 300; n++) begin
            logic [4:0] p, a;
            logic st;
            rs = $urandom; p = 5'($urandom); a = 5'($urandom); st = 1'(n & 1);
            send(rs, p, a, st, model(rs, p, a, st), st ? "R6 random stripe" : "R5 random");
            if ((n % 7) == 0) idle();
        end

        // R3: result holds across idle cycles with changing data.
        send(32'h12345678, 5'd3, 5'd17, 1'b1, model(32'h12345678, 5'd3, 5'd17, 1'b1), "R5 before hold");
        held = model(32'h12345678, 5'd3, 5'd17, 1'b1);
        idle();
        @(negedge clk);
        check(result === held, "R3 hold after idle", result, held);
        check(out_valid === 1'b0, "R2 out_valid low after idle", {63'd0, out_valid}, 64'd0);
        in_valid = 1'b0; src = 32'hFFFFFFFF; shamt = 5'd31;
        @(negedge clk);
        check(result === held, "R3 hold second idle", result, held);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2 every input produced a result",
              64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule